// File: doc/BRIEF.md
# Difference-of-Means Key Byte Ranker

This block ranks all 256 guesses for one byte of a block-cipher key using a stream of measurement records. Each record carries a known plaintext byte and one signed measurement taken at a fixed instant of the capture. For each guess the block predicts one bit: the low bit of the AES forward substitution of (plaintext XOR guess). That bit puts the measurement into one of two groups for that guess. Every guess keeps its group-1 running sum and group-1 count. The group-0 figures come from record-wide totals.

Once all records are in, a finish pulse starts a scan over the guesses. The scan picks the guess whose group means differ most in magnitude, and reports that guess together with its score as a numerator/denominator pair, so no divider is needed. A full 16-byte key is recovered by running the block once per byte position, each time feeding that position's plaintext byte.

The controller has five states. CLEAR wipes one candidate slot per cycle. LOAD waits for a record, a finish or a start. ACCUM updates one candidate per cycle. SCAN ranks one candidate per cycle. DONE holds the result. The transitions are:
- reset goes to CLEAR;
- CLEAR goes to LOAD after its last slot;
- LOAD goes to CLEAR on start, otherwise to SCAN on finish, otherwise to ACCUM on in_valid;
- ACCUM goes to LOAD after its last candidate;
- SCAN goes to DONE after its last candidate;
- DONE goes to CLEAR on start.

Top module: `dom_key_search`

## Requirements
- R1: After reset, and after an accepted start pulse, the block spends exactly 256 cycles clearing with in_ready and done low, then raises in_ready.
- R2: For record plaintext p and guess k (0..255), the selection bit is bit 0 of the AES forward S-box of (p XOR k). A bit of 1 places the sample in group 1 of guess k, and a bit of 0 places it in group 0.
- R3: Group sums are SAMPLE_W+CNT_W bits and counts are CNT_W bits, so up to 2^CNT_W-1 records (65535 by default) accumulate without wrap-around. Every accepted record raises the record count by exactly one.
- R4: A record is taken on a clock edge where state is LOAD, in_valid is high and neither start nor finish is high. in_ready then stays low for exactly 256 cycles while each guess is updated in turn.
- R5: The score of guess k is score_num/score_den, where score_num = S1*N0 - S0*N1 (signed), score_den = N1*N0, S and N are the group sums and counts, and the group-1 mean comes first. A guess with an empty group scores zero.
- R6: key_out is the guess with the largest |score|, and the lowest index wins a tie. When every guess scores zero, key_out, score_num and score_den are all 0.
- R7: A taken finish pulse in LOAD starts a 256-cycle scan. done then rises and stays high, with stable results and in_ready low, until a start pulse.
- R8: start is acted on only in LOAD or DONE. In LOAD, start has priority over finish, and finish has priority over in_valid. After start, done is low and all earlier records are forgotten.
- R9: in_sample is two's complement. Negative samples add into the sums with their sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: clear all groups and begin a new run |
| finish | input | 1 | Pulse: rank the guesses for the records loaded so far |
| in_valid | input | 1 | Record present on in_pt and in_sample |
| in_ready | output | 1 | Block can take a record (LOAD state) |
| in_pt | input | 8 | Known plaintext byte of the record |
| in_sample | input | SAMPLE_W | Signed measurement of the record |
| done | output | 1 | Ranking finished; results valid |
| key_out | output | 8 | Winning key byte guess |
| score_num | output | SAMPLE_W+2*CNT_W+1 | Signed numerator of the winning score |
| score_den | output | 2*CNT_W | Denominator of the winning score (0 if no guess scored) |

## Verification
The assertions check the following on every cycle:
- in_ready drops after each taken record and returns only after 256 low cycles, whether the low stretch is a record update or a clear;
- the record count steps by one per record and never wraps;
- done holds until start and excludes in_ready;
- a zero denominator comes with a zero numerator and guess 0, and a nonzero denominator comes with a nonzero numerator.

Which guess wins, the exact numerator and denominator, tie resolution toward the lowest index, the priority of finish over a simultaneous record, and correct handling of negative samples can only be shown by the bench scenarios. The bench compares each of these against an independent model of the grouping.

// File: rtl/dom_pkg.sv
package dom_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_LOAD,
        ST_ACCUM,
        ST_SCAN,
        ST_DONE
    } dom_state_e;

    // Multiply by x in GF(2^8) with the AES reduction polynomial.
    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Field inverse as a^254 (maps 0 to 0).
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] sq;
        r  = 8'h01;
        sq = a;
        for (int i = 1; i < 8; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        logic [15:0] d;
        d = {v, v} << n;
        return d[15:8];
    endfunction

    // AES forward substitution: inversion followed by the affine map.
    function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
        logic [7:0] v;
        v = gf_inv(x);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/dom_select.sv
module dom_select #(
    parameter logic [7:0] SEL_MASK = 8'h01
) (
    input  logic [7:0] pt,
    input  logic [7:0] cand,
    output logic       sel
);
    logic [7:0] sub;

    assign sub = dom_pkg::sbox_fwd(pt ^ cand);
    assign sel = |(sub & SEL_MASK);

endmodule

// File: rtl/dom_acc_bank.sv
module dom_acc_bank #(
    parameter  int NCAND    = 256,
    parameter  int SAMPLE_W = 16,
    parameter  int CNT_W    = 16,
    localparam int IDX_W    = $clog2(NCAND),
    localparam int SUM_W    = SAMPLE_W + CNT_W
) (
    input  logic                       clk,
    input  logic                       clr_en,
    input  logic                       upd_en,
    input  logic [IDX_W-1:0]           idx,
    input  logic                       upd_sel,
    input  logic signed [SAMPLE_W-1:0] upd_sample,
    output logic signed [SUM_W-1:0]    rd_sum1,
    output logic [CNT_W-1:0]           rd_cnt1
);
    logic signed [SUM_W-1:0] sum1_mem [NCAND];
    logic [CNT_W-1:0]        cnt1_mem [NCAND];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            sum1_mem[idx] <= '0;
            cnt1_mem[idx] <= '0;
        end else if (upd_en && upd_sel) begin
            sum1_mem[idx] <= sum1_mem[idx] + SUM_W'(upd_sample);
            cnt1_mem[idx] <= cnt1_mem[idx] + 1'b1;
        end
    end

    assign rd_sum1 = sum1_mem[idx];
    assign rd_cnt1 = cnt1_mem[idx];

endmodule

// File: rtl/dom_score.sv
module dom_score #(
    parameter  int SAMPLE_W = 16,
    parameter  int CNT_W    = 16,
    localparam int SUM_W    = SAMPLE_W + CNT_W,
    localparam int NUM_W    = SUM_W + CNT_W + 1,
    localparam int DEN_W    = 2 * CNT_W
) (
    input  logic signed [SUM_W-1:0] sum1,
    input  logic [CNT_W-1:0]        cnt1,
    input  logic signed [SUM_W-1:0] tot_sum,
    input  logic [CNT_W-1:0]        tot_cnt,
    output logic signed [NUM_W-1:0] num,
    output logic [NUM_W-1:0]        mag,
    output logic [DEN_W-1:0]        den
);
    logic [CNT_W-1:0]        cnt0;
    logic signed [SUM_W-1:0] sum0;
    logic signed [NUM_W-1:0] s1x, s0x, c1x, c0x, raw;
    logic                    empty;

    assign cnt0  = tot_cnt - cnt1;
    assign sum0  = tot_sum - sum1;
    assign s1x   = NUM_W'(sum1);
    assign s0x   = NUM_W'(sum0);
    assign c1x   = NUM_W'(cnt1);
    assign c0x   = NUM_W'(cnt0);
    assign raw   = (s1x * c0x) - (s0x * c1x);
    assign empty = (cnt1 == '0) || (cnt0 == '0);

    assign num = empty ? '0 : raw;
    assign den = empty ? '0 : DEN_W'(cnt1) * DEN_W'(cnt0);
    assign mag = num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);

endmodule

// File: rtl/dom_argmax.sv
module dom_argmax #(
    parameter  int IDX_W  = 8,
    parameter  int NUM_W  = 49,
    parameter  int DEN_W  = 32,
    localparam int PROD_W = NUM_W + DEN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    init,
    input  logic                    step,
    input  logic [IDX_W-1:0]        cand_idx,
    input  logic signed [NUM_W-1:0] cand_num,
    input  logic [NUM_W-1:0]        cand_mag,
    input  logic [DEN_W-1:0]        cand_den,
    output logic [IDX_W-1:0]        best_idx,
    output logic signed [NUM_W-1:0] best_num,
    output logic [DEN_W-1:0]        best_den
);
    logic [NUM_W-1:0]  best_mag;
    logic [PROD_W-1:0] lhs, rhs;
    logic              better;

    // |n_c|/d_c > |n_b|/d_b  <=>  |n_c|*d_b > |n_b|*d_c (both denominators positive)
    assign lhs    = PROD_W'(cand_mag) * PROD_W'(best_den);
    assign rhs    = PROD_W'(best_mag) * PROD_W'(cand_den);
    assign better = (cand_mag != '0) && ((best_den == '0) || (lhs > rhs));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_idx <= '0;
            best_num <= '0;
            best_mag <= '0;
            best_den <= '0;
        end else if (init) begin
            best_idx <= '0;
            best_num <= '0;
            best_mag <= '0;
            best_den <= '0;
        end else if (step && better) begin
            best_idx <= cand_idx;
            best_num <= cand_num;
            best_mag <= cand_mag;
            best_den <= cand_den;
        end
    end

endmodule

// File: rtl/dom_key_search.sv
module dom_key_search #(
    parameter  int SAMPLE_W = 16,
    parameter  int CNT_W    = 16,
    localparam int NCAND    = 256,
    localparam int IDX_W    = $clog2(NCAND),
    localparam int SUM_W    = SAMPLE_W + CNT_W,
    localparam int NUM_W    = SUM_W + CNT_W + 1,
    localparam int DEN_W    = 2 * CNT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       finish,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [7:0]                 in_pt,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       done,
    output logic [7:0]                 key_out,
    output logic signed [NUM_W-1:0]    score_num,
    output logic [DEN_W-1:0]           score_den
);
    import dom_pkg::*;

    dom_state_e              state_q, state_d;
    logic [IDX_W-1:0]        idx_q;
    logic [7:0]              pt_q;
    logic signed [SAMPLE_W-1:0] smp_q;
    logic signed [SUM_W-1:0] tot_sum_q;
    logic [CNT_W-1:0]        tot_cnt_q;

    logic                    idx_last, walking, accept, sel_bit;
    logic signed [SUM_W-1:0] rd_sum1;
    logic [CNT_W-1:0]        rd_cnt1;
    logic signed [NUM_W-1:0] c_num, b_num;
    logic [NUM_W-1:0]        c_mag;
    logic [DEN_W-1:0]        c_den, b_den;
    logic [IDX_W-1:0]        b_idx;

    assign idx_last = (idx_q == IDX_W'(NCAND - 1));
    assign walking  = (state_q == ST_CLEAR) || (state_q == ST_ACCUM) || (state_q == ST_SCAN);
    assign accept   = (state_q == ST_LOAD) && in_valid && !start && !finish;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (idx_last) state_d = ST_LOAD;
            ST_LOAD: begin
                if (start)         state_d = ST_CLEAR;
                else if (finish)   state_d = ST_SCAN;
                else if (in_valid) state_d = ST_ACCUM;
            end
            ST_ACCUM: if (idx_last) state_d = ST_LOAD;
            ST_SCAN:  if (idx_last) state_d = ST_DONE;
            ST_DONE:  if (start)    state_d = ST_CLEAR;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // Candidate walker and record registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            pt_q      <= '0;
            smp_q     <= '0;
            tot_sum_q <= '0;
            tot_cnt_q <= '0;
        end else begin
            if (state_d != state_q) idx_q <= '0;
            else if (walking)       idx_q <= idx_q + 1'b1;

            if (state_q == ST_CLEAR) begin
                tot_sum_q <= '0;
                tot_cnt_q <= '0;
            end else if (accept) begin
                pt_q      <= in_pt;
                smp_q     <= in_sample;
                tot_sum_q <= tot_sum_q + SUM_W'(in_sample);
                tot_cnt_q <= tot_cnt_q + 1'b1;
            end
        end
    end

    dom_select #(.SEL_MASK(8'h01)) u_sel (
        .pt   (pt_q),
        .cand (idx_q),
        .sel  (sel_bit)
    );

    dom_acc_bank #(.NCAND(NCAND), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_bank (
        .clk        (clk),
        .clr_en     (state_q == ST_CLEAR),
        .upd_en     (state_q == ST_ACCUM),
        .idx        (idx_q),
        .upd_sel    (sel_bit),
        .upd_sample (smp_q),
        .rd_sum1    (rd_sum1),
        .rd_cnt1    (rd_cnt1)
    );

    dom_score #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_score (
        .sum1    (rd_sum1),
        .cnt1    (rd_cnt1),
        .tot_sum (tot_sum_q),
        .tot_cnt (tot_cnt_q),
        .num     (c_num),
        .mag     (c_mag),
        .den     (c_den)
    );

    dom_argmax #(.IDX_W(IDX_W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_best (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (state_q == ST_CLEAR),
        .step     (state_q == ST_SCAN),
        .cand_idx (idx_q),
        .cand_num (c_num),
        .cand_mag (c_mag),
        .cand_den (c_den),
        .best_idx (b_idx),
        .best_num (b_num),
        .best_den (b_den)
    );

    // Outputs
    always_comb begin
        in_ready  = (state_q == ST_LOAD);
        done      = (state_q == ST_DONE);
        key_out   = b_idx;
        score_num = b_num;
        score_den = b_den;
    end

endmodule

// File: rtl/dom_key_search_chk.sv
module dom_key_search_chk #(
    parameter int CNT_W = 16,
    parameter int NUM_W = 49,
    parameter int DEN_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    finish,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    done,
    input logic [7:0]              key_out,
    input logic signed [NUM_W-1:0] score_num,
    input logic [DEN_W-1:0]        score_den,
    input logic [CNT_W-1:0]        tot_cnt_q
);
    logic        took;
    logic [15:0] low_run;

    assign took = in_valid && in_ready && !start && !finish;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      low_run <= '0;
        else if (in_ready || (done && start)) low_run <= '0;
        else if (low_run != 16'hffff)    low_run <= low_run + 1'b1;
    end

    // R4 and R1: every low stretch of in_ready lasts exactly 256 cycles
    a_r4_busy_256: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> (low_run == 16'd256));

    a_r4_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> !in_ready);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        took |-> (tot_cnt_q != '1));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> (tot_cnt_q == CNT_W'($past(tot_cnt_q) + 1'b1)));

    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(key_out) && $stable(score_num) && $stable(score_den)));

    a_r7_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    a_r8_start_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    a_r6_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && score_den == '0) |-> (score_num == '0 && key_out == 8'd0));

    a_r5_nonzero_score: assert property (@(posedge clk) disable iff (!rst_n)
        (done && score_den != '0) |-> (score_num != '0));

endmodule

bind dom_key_search dom_key_search_chk #(
    .CNT_W(CNT_W), .NUM_W(NUM_W), .DEN_W(DEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .finish    (finish),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .done      (done),
    .key_out   (key_out),
    .score_num (score_num),
    .score_den (score_den),
    .tot_cnt_q (tot_cnt_q)
);

// File: tb/sim_dom_key_search.sv
module sim_dom_key_search;
    localparam int SAMPLE_W = 16;
    localparam int CNT_W    = 16;
    localparam int NUM_W    = SAMPLE_W + 2 * CNT_W + 1;
    localparam int DEN_W    = 2 * CNT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, finish = 1'b0, in_valid = 1'b0;
    logic [7:0] in_pt = '0;
    logic signed [SAMPLE_W-1:0] in_sample = '0;
    logic in_ready, done;
    logic [7:0] key_out;
    logic signed [NUM_W-1:0] score_num;
    logic [DEN_W-1:0] score_den;

    always #5 clk = ~clk;

    dom_key_search #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .finish(finish),
        .in_valid(in_valid), .in_ready(in_ready), .in_pt(in_pt), .in_sample(in_sample),
        .done(done), .key_out(key_out), .score_num(score_num), .score_den(score_den)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Independent S-box reference: inverse by search, affine map bit by bit.
    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] b_sbox(input logic [7:0] v);
        logic [7:0] inv = 0;
        logic [7:0] o;
        logic [7:0] c = 8'h63;
        if (v != 0)
            for (int y = 1; y < 256; y++)
                if (b_mul(v, 8'(y)) == 8'h01) inv = 8'(y);
        for (int i = 0; i < 8; i++)
            o[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8] ^ inv[(i + 6) % 8]
                   ^ inv[(i + 7) % 8] ^ c[i];
        return o;
    endfunction

    logic [7:0] ref_sb [256];
    longint m_sum1 [256];
    longint m_cnt1 [256];
    longint m_tsum, m_tcnt;

    typedef struct {
        int     key;
        longint num;
        longint den;
        string  key_req;
        string  tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic model_clear();
        for (int k = 0; k < 256; k++) begin
            m_sum1[k] = 0;
            m_cnt1[k] = 0;
        end
        m_tsum = 0;
        m_tcnt = 0;
    endtask

    task automatic model_add(input logic [7:0] pt, input int s);
        for (int k = 0; k < 256; k++)
            if (ref_sb[pt ^ 8'(k)][0]) begin
                m_sum1[k] += s;
                m_cnt1[k] += 1;
            end
        m_tsum += s;
        m_tcnt += 1;
    endtask

    function automatic longint labs(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    // Driver side of the scoreboard: push the expected ranking.
    task automatic push_expect(input string key_req, input string tag);
        exp_t e;
        e.key = 0; e.num = 0; e.den = 0; e.key_req = key_req; e.tag = tag;
        for (int k = 0; k < 256; k++) begin
            longint c1, c0, s1, s0, n, d;
            c1 = m_cnt1[k]; c0 = m_tcnt - c1;
            if (c1 != 0 && c0 != 0) begin
                s1 = m_sum1[k]; s0 = m_tsum - s1;
                n = s1 * c0 - s0 * c1;
                d = c1 * c0;
                if (n != 0 && (e.den == 0 || labs(n) * e.den > labs(e.num) * d)) begin
                    e.key = k; e.num = n; e.den = d;
                end
            end
        end
        sb_q.push_back(e);
    endtask

    // Monitor side: pop and compare on each rising done.
    initial begin
        bit prev = 0;
        forever begin
            @(negedge clk);
            if (done && !prev) begin
                if (sb_q.size() == 0) begin
                    check(0, "R7", "result without request", key_out, -1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(key_out == e.key, e.key_req, {e.tag, " key"}, key_out, e.key);
                    check(longint'(score_num) == e.num, "R5", {e.tag, " numerator"},
                          longint'(score_num), e.num);
                    check(longint'(score_den) == e.den, "R5", {e.tag, " denominator"},
                          longint'(score_den), e.den);
                end
            end
            prev = done;
        end
    end

    task automatic send(input logic [7:0] pt, input int s);
        int n;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_pt = pt; in_sample = SAMPLE_W'(s);
        @(negedge clk);
        in_valid = 0;
        check(!in_ready, "R4", "ready after take", in_ready, 0);
        n = 0;
        while (!in_ready) begin @(negedge clk); n++; end
        check(n == 256, "R4", "busy cycles per record", n, 256);
        model_add(pt, s);
    endtask

    task automatic run_finish(input string key_req, input string tag);
        int n;
        while (!in_ready) @(negedge clk);
        finish = 1;
        push_expect(key_req, tag);
        @(negedge clk);
        finish = 0;
        n = 0;
        while (!done) begin @(negedge clk); n++; end
        check(n == 256, "R7", "scan cycles", n, 256);
    endtask

    task automatic run_start();
        int n;
        while (!(in_ready || done)) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        model_clear();
        check(!done, "R8", "done after start", done, 0);
        check(!in_ready, "R1", "ready during clear", in_ready, 0);
        n = 0;
        while (!in_ready) begin @(negedge clk); n++; end
        check(n == 256, "R1", "clear cycles after start", n, 256);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL R7 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        for (int v = 0; v < 256; v++) ref_sb[v] = b_sbox(8'(v));
        model_clear();

        // R1: reset state and clear length
        repeat (3) @(negedge clk);
        check(!in_ready, "R1", "ready in reset", in_ready, 0);
        check(!done, "R1", "done in reset", done, 0);
        rst_n = 1;
        n = 0;
        while (!in_ready) begin @(negedge clk); n++; end
        check(n == 256, "R1", "clear cycles after reset", n, 256);

        // R6: no records at all -> everything zero; R7: done holds
        run_finish("R6", "empty run");
        repeat (20) @(negedge clk);
        check(done, "R7", "done held", done, 1);
        check(!in_ready, "R7", "ready while done", in_ready, 0);
        run_start();

        // R5: one record leaves one group empty for every guess
        send(8'h55, 1234);
        run_finish("R5", "single record");
        run_start();

        // R8: finish beats a simultaneous record
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_pt = 8'h9a; in_sample = SAMPLE_W'(700); finish = 1;
        push_expect("R8", "finish over record");
        @(negedge clk);
        in_valid = 0; finish = 0;
        while (!done) @(negedge clk);
        run_start();

        // R6: two records give many equal scores; lowest index must win
        send(8'h3e, 10);
        send(8'hc1, 0);
        run_finish("R6", "tie");
        run_start();

        // R2 and R3: planted dependence on guess 0x3c
        for (int i = 0; i < 48; i++) begin
            logic [7:0] p;
            p = 8'((i * 37 + 11) & 255);
            send(p, (ref_sb[p ^ 8'h3c][0] ? 900 : -100) + (i % 7) - 3);
        end
        run_finish("R2", "planted key R3 wide sums");
        run_start();

        // R9: large negative samples, planted guess 0xa7
        for (int i = 0; i < 40; i++) begin
            logic [7:0] p;
            p = 8'((i * 53 + 200) & 255);
            send(p, ref_sb[p ^ 8'ha7][0] ? -30000 : (1200 + i));
        end
        run_finish("R9", "negative samples");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R7", "results pending", sb_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule